// File: doc/BRIEF.md
# PCI Host Bridge Control Register Block

This block is the CPU-facing register file of an on-chip PCI host controller. A 32-bit register bus reaches four things through it. The first is a private copy of the host's own 256-byte configuration header. The second is a configuration address register, also called the target register. The third is a pair of window base registers, one for memory and one for I/O. The fourth is a data port, which forwards each CPU access as a single 4-byte request on a small valid/ready configuration interface. The target of that request is the address held in the target register.

Ordinary register accesses complete in the cycle they are presented. A data-port access stalls the CPU until the configuration side answers, and read data returns on the same cycle as that answer. A combinational decoder compares a CPU address against the programmed I/O base. It reports a hit inside the 256 KiB I/O window and gives the offset inside it. A small router turns interrupt events from downstream devices into four level outputs. The router selects the output line from the device number.

Top module: `pcib_regs`

## Requirements
- R1: Byte offsets 0x000 to 0x0FC (word aligned) address the 64 words of the local configuration header. Each word is read and written as a whole 32-bit value.
- R2: After reset, the header word at 0x004 reads 0x02900080, the I/O base reads 0xFE240000, and every other header word and register reads zero. In 0x02900080, command bit 7 is wait-cycle control, and status bits 4, 7 and 9 are capability list, fast back-to-back and medium select timing.
- R3: The target register at 0x1C0 keeps all 32 written bits and reads them back unchanged.
- R4: The memory base at 0x1C4 keeps only written bits 31:24 and bit 0 (mask 0xFF000001). All other bits read zero.
- R5: The I/O base at 0x1C8 keeps only bits 31:18 and bit 0 (mask 0xFFFC0001). A write takes effect only when its bits 31:18 differ from the stored ones. Otherwise the whole write is dropped, bit 0 included.
- R6: `win_hit` is high exactly when `win_addr[31:18]` equals the I/O base bits 31:18, and `win_offset` equals `win_addr[17:0]`. The decoder follows a new base from the cycle after the accepting write.
- R7: An access to 0x220 raises `cfg_valid` with `cfg_addr` equal to the target register, and `cfg_we` and `cfg_wdata` taken from the CPU access. These are held until `cfg_ready`. `bus_ack` rises in the `cfg_ready` cycle, and for a read `bus_rdata` then equals `cfg_rdata`.
- R8: Offsets outside the decoded registers read zero, and writes to them change nothing. This covers 0x100 to 0x1BC, 0x1CC to 0x21C, offsets from 0x224 up, and any offset with bits 1:0 not zero.
- R9: An event with `irq_evt` high sets output line N of `irq_out` to `irq_level` one cycle later, where N is `irq_devfn[7:3]`. Events with N of 4 or more are ignored.
- R10: Every access other than to 0x220 is acknowledged combinationally in the cycle `bus_req` is presented. Its write takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | CPU access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completes this cycle |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Configuration request is a write |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ready | input | 1 | Configuration side answers this cycle |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ready` |
| win_addr | input | 32 | CPU address to classify |
| win_hit | output | 1 | Address falls in the I/O window |
| win_offset | output | 18 | Offset inside the I/O window |
| irq_evt | input | 1 | Downstream interrupt level change |
| irq_devfn | input | 8 | Device/function number of the source |
| irq_level | input | 1 | New interrupt level |
| irq_out | output | 4 | Interrupt lines, one per device number |

## Verification
Some checks run on every cycle:
- The write masks for the target register and the memory base.
- The rule that an I/O base write with unchanged upper bits leaves the register untouched.
- A pending configuration request holding steady until it is answered, and then ending.
- No more than one interrupt line changing in a cycle.

Other behaviour only the bench scenarios can show: the header reset image, the aliasing and undecoded gaps of the address map, single-cycle acknowledge timing, and the data port's actual addresses and data under different response latencies. The bench's reference model tracks the I/O base and the interrupt lines and compares the window decoder and `irq_out` on every clock.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

    localparam int unsigned DATA_W = 32;

    localparam logic [11:0] OFF_TARGET = 12'h1C0;
    localparam logic [11:0] OFF_MEMBAS = 12'h1C4;
    localparam logic [11:0] OFF_IOBAS  = 12'h1C8;
    localparam logic [11:0] OFF_PORT   = 12'h220;

    localparam logic [DATA_W-1:0] MEMBAS_KEEP = 32'hFF00_0001;
    localparam logic [DATA_W-1:0] IOBAS_KEEP  = 32'hFFFC_0001;
    localparam logic [DATA_W-1:0] IOBAS_INIT  = 32'hFE24_0000;

    // command word: wait-cycle control (bit 7)
    // status word : capability list (4), fast back-to-back (7), medium timing (9)
    localparam logic [15:0] CMD_INIT  = 16'h0080;
    localparam logic [15:0] STAT_INIT = 16'h0290;
    localparam int unsigned CMDSTAT_WORD = 1;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_WAIT = 1'b1
    } port_st_e;

    typedef struct packed {
        port_st_e          st;
        logic [DATA_W-1:0] target;
        logic [DATA_W-1:0] membas;
        logic [DATA_W-1:0] iobas;
        logic              pend_we;
        logic [DATA_W-1:0] pend_wdata;
    } ctl_state_t;

endpackage

// File: rtl/pcib_hdr_store.sv
module pcib_hdr_store
    import pcib_pkg::*;
#(
    parameter int unsigned WORDS = 64,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] hdr_d [WORDS];
    logic [DATA_W-1:0] hdr_q [WORDS];

    always_comb begin
        hdr_d = hdr_q;
        if (wr_en) begin
            hdr_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                hdr_q[i] <= (i == CMDSTAT_WORD) ? {STAT_INIT, CMD_INIT} : '0;
            end
        end else begin
            hdr_q <= hdr_d;
        end
    end

    assign rd_data = hdr_q[rd_idx];

    // a write lands in the addressed word on the next cycle
    AST_HDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hdr_q[$past(wr_idx)] == $past(wr_data)); // R1

endmodule

// File: rtl/pcib_io_window.sv
module pcib_io_window #(
    parameter int unsigned AW       = 32,
    parameter int unsigned WIN_BITS = 18
) (
    input  logic [AW-1:WIN_BITS] base_hi,
    input  logic [AW-1:0]        addr,
    output logic                 hit,
    output logic [WIN_BITS-1:0]  offset
);

    always_comb begin
        hit    = (addr[AW-1:WIN_BITS] == base_hi);
        offset = addr[WIN_BITS-1:0];
    end

endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
    parameter int unsigned LINES   = 4,
    parameter int unsigned DEVFN_W = 8,
    parameter int unsigned DEV_LSB = 3,
    localparam int unsigned DEV_W  = DEVFN_W - DEV_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic               level,
    output logic [LINES-1:0]   lines
);

    logic [DEV_W-1:0] dev_num;
    logic [LINES-1:0] sel;
    logic [LINES-1:0] lines_d, lines_q;
    logic             unused_fn_bits;

    assign dev_num        = devfn[DEVFN_W-1:DEV_LSB];
    assign unused_fn_bits = ^devfn[DEV_LSB-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_sel
        assign sel[g] = evt && (dev_num == DEV_W'(g));
    end

    always_comb begin
        lines_d = lines_q;
        for (int i = 0; i < LINES; i++) begin
            if (sel[i]) begin
                lines_d[i] = level;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= lines_d;
        end
    end

    assign lines = lines_q;

    AST_IRQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines_q ^ $past(lines_q)) <= 1); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(lines_q)); // R9

endmodule

// File: rtl/pcib_regs.sv
module pcib_regs
    import pcib_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned HDR_BYTES = 256,
    parameter int unsigned WIN_BITS  = 18,
    parameter int unsigned IRQ_LINES = 4,
    localparam int unsigned HDR_WORDS = HDR_BYTES / 4,
    localparam int unsigned HDR_IDX_W = $clog2(HDR_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ack,
    output logic                cfg_valid,
    output logic                cfg_we,
    output logic [DATA_W-1:0]   cfg_addr,
    output logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_ready,
    input  logic [DATA_W-1:0]   cfg_rdata,
    input  logic [DATA_W-1:0]   win_addr,
    output logic                win_hit,
    output logic [WIN_BITS-1:0] win_offset,
    input  logic                irq_evt,
    input  logic [7:0]          irq_devfn,
    input  logic                irq_level,
    output logic [IRQ_LINES-1:0] irq_out
);

    ctl_state_t st_d, st_q;

    // ---------------- address decode ----------------
    logic aligned, sel_hdr, sel_target, sel_membas, sel_iobas, sel_port;

    always_comb begin
        aligned    = (bus_addr[1:0] == 2'b00);
        sel_hdr    = aligned && (bus_addr < ADDR_W'(HDR_BYTES));
        sel_target = (bus_addr == ADDR_W'(OFF_TARGET));
        sel_membas = (bus_addr == ADDR_W'(OFF_MEMBAS));
        sel_iobas  = (bus_addr == ADDR_W'(OFF_IOBAS));
        sel_port   = (bus_addr == ADDR_W'(OFF_PORT));
    end

    // ---------------- header copy ----------------
    logic                 hdr_wr;
    logic [HDR_IDX_W-1:0] hdr_idx;
    logic [DATA_W-1:0]    hdr_rd;

    assign hdr_idx = bus_addr[HDR_IDX_W+1:2];

    pcib_hdr_store #(
        .WORDS (HDR_WORDS)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hdr_wr),
        .wr_idx  (hdr_idx),
        .wr_data (bus_wdata),
        .rd_idx  (hdr_idx),
        .rd_data (hdr_rd)
    );

    // ---------------- next-state logic ----------------
    logic iobas_moves;
    assign iobas_moves = (bus_wdata[DATA_W-1:WIN_BITS] != st_q.iobas[DATA_W-1:WIN_BITS]);

    always_comb begin
        st_d      = st_q;
        hdr_wr    = 1'b0;
        bus_ack   = 1'b0;
        bus_rdata = '0;

        unique case (st_q.st)
            PORT_IDLE: begin
                if (bus_req) begin
                    if (sel_port) begin
                        st_d.st         = PORT_WAIT;
                        st_d.pend_we    = bus_we;
                        st_d.pend_wdata = bus_wdata;
                    end else begin
                        bus_ack = 1'b1;
                        if (sel_hdr)         bus_rdata = hdr_rd;
                        else if (sel_target) bus_rdata = st_q.target;
                        else if (sel_membas) bus_rdata = st_q.membas;
                        else if (sel_iobas)  bus_rdata = st_q.iobas;

                        if (bus_we) begin
                            hdr_wr = sel_hdr;
                            if (sel_target) st_d.target = bus_wdata;
                            if (sel_membas) st_d.membas = bus_wdata & MEMBAS_KEEP;
                            if (sel_iobas && iobas_moves) st_d.iobas = bus_wdata & IOBAS_KEEP;
                        end
                    end
                end
            end
            PORT_WAIT: begin
                if (cfg_ready) begin
                    bus_ack = 1'b1;
                    if (!st_q.pend_we) bus_rdata = cfg_rdata;
                    st_d.st = PORT_IDLE;
                end
            end
            default: st_d.st = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st         <= PORT_IDLE;
            st_q.target     <= '0;
            st_q.membas     <= '0;
            st_q.iobas      <= IOBAS_INIT;
            st_q.pend_we    <= 1'b0;
            st_q.pend_wdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- configuration interface ----------------
    assign cfg_valid = (st_q.st == PORT_WAIT);
    assign cfg_we    = st_q.pend_we;
    assign cfg_addr  = st_q.target;
    assign cfg_wdata = st_q.pend_wdata;

    // ---------------- I/O window decoder ----------------
    pcib_io_window #(
        .AW       (DATA_W),
        .WIN_BITS (WIN_BITS)
    ) u_win (
        .base_hi (st_q.iobas[DATA_W-1:WIN_BITS]),
        .addr    (win_addr),
        .hit     (win_hit),
        .offset  (win_offset)
    );

    // ---------------- interrupt routing ----------------
    pcib_irq_route #(
        .LINES   (IRQ_LINES),
        .DEVFN_W (8),
        .DEV_LSB (3)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (irq_evt),
        .devfn (irq_devfn),
        .level (irq_level),
        .lines (irq_out)
    );

    // ---------------- assertions ----------------
    AST_TARGET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_we && sel_target && !cfg_valid
        |=> cfg_addr == $past(bus_wdata)); // R3

    AST_MEMBAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_we && sel_membas && !cfg_valid
        |=> st_q.membas == ($past(bus_wdata) & MEMBAS_KEEP)); // R4

    AST_IOBAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_we && sel_iobas && !cfg_valid
        && (bus_wdata[DATA_W-1:WIN_BITS] == st_q.iobas[DATA_W-1:WIN_BITS])
        |=> $stable(st_q.iobas)); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready
        |=> cfg_valid && $stable(cfg_addr) && $stable(cfg_we) && $stable(cfg_wdata)); // R7

    AST_REQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ready |=> !cfg_valid); // R7

endmodule

// File: tb/sim_pcib_regs.sv
`timescale 1ns/1ps
module sim_pcib_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        cfg_valid, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic        cfg_ready = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [31:0] win_addr = '0;
    logic        win_hit;
    logic [17:0] win_offset;
    logic        irq_evt = 1'b0, irq_level = 1'b0;
    logic [7:0]  irq_devfn = '0;
    logic [3:0]  irq_out;

    always #5 clk = ~clk;

    pcib_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .cfg_valid(cfg_valid), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
        .win_addr(win_addr), .win_hit(win_hit), .win_offset(win_offset),
        .irq_evt(irq_evt), .irq_devfn(irq_devfn), .irq_level(irq_level),
        .irq_out(irq_out)
    );

    int vectors = 0, errs = 0;
    bit running = 1'b0;

    // reference model state
    logic [31:0] mdl_iobas = 32'hFE24_0000;
    logic [3:0]  mdl_irq   = '0;
    bit   [31:0] cfg_mem [bit [31:0]];
    int          cfg_lat = 0;
    logic [31:0] seen_addr, seen_wdata;
    logic        seen_we;
    int          seen_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // configuration-side responder with programmable latency
    initial begin : responder
        int cnt = 0;
        forever begin
            @(posedge clk); #2;
            if (cfg_valid && !cfg_ready) begin
                if (cnt >= cfg_lat) begin
                    cfg_ready  = 1'b1;
                    cfg_rdata  = cfg_mem.exists(cfg_addr) ? cfg_mem[cfg_addr] : (cfg_addr ^ 32'h5A5A_5A5A);
                    seen_addr  = cfg_addr;
                    seen_we    = cfg_we;
                    seen_wdata = cfg_wdata;
                    seen_cnt++;
                    if (cfg_we) cfg_mem[cfg_addr] = cfg_wdata;
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end else begin
                cfg_ready = 1'b0;
                cfg_rdata = '0;
                cnt = 0;
            end
        end
    end

    // per-clock comparison of window decoder and interrupt lines (R6, R9)
    initial begin : per_clock
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            win_addr = k[0] ? {mdl_iobas[31:18], 18'(k * 37)} : 32'(k) * 32'h9E37_79B9;
            #1;
            if (running) begin
                chk(win_hit == (win_addr[31:18] == mdl_iobas[31:18]), "R6 hit", {31'b0, win_hit},
                    {31'b0, win_addr[31:18] == mdl_iobas[31:18]});
                chk(win_offset == win_addr[17:0], "R6 offset", {14'b0, win_offset}, {14'b0, win_addr[17:0]});
                chk(irq_out == mdl_irq, "R9 lines", {28'b0, irq_out}, {28'b0, mdl_irq});
            end
        end
    end

    task automatic acc(input bit we, input logic [11:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        waits = 0;
        forever begin
            #1;
            if (bus_ack) begin
                rd = bus_rdata;
                break;
            end
            @(negedge clk);
            waits++;
        end
        @(posedge clk);
        if (we && a == 12'h1C8 && wd[31:18] != mdl_iobas[31:18]) mdl_iobas = wd & 32'hFFFC_0001;
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] wd, input string tag);
        logic [31:0] rd; int w;
        acc(1'b1, a, wd, rd, w);
        if (a != 12'h220) chk(w == 0, tag, w, 0);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] rd; int w;
        acc(1'b0, a, '0, rd, w);
        chk(rd == exp, tag, rd, exp);
        if (a != 12'h220) chk(w == 0, "R10 single-cycle read", w, 0);
    endtask

    task automatic irq_send(input logic [7:0] fn, input logic lvl);
        @(negedge clk);
        irq_evt = 1'b1; irq_devfn = fn; irq_level = lvl;
        @(posedge clk);
        if (fn[7:3] < 4) mdl_irq[fn[4:3]] = lvl;
        #1;
        irq_evt = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual %h expected %h", 32'd20000, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin : main
        logic [31:0] r; int w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        running = 1'b1;

        // reset image R2
        rd_chk(12'h004, 32'h0290_0080, "R2 cmd/status");
        rd_chk(12'h000, 32'h0, "R2 header word 0");
        rd_chk(12'h0FC, 32'h0, "R2 header last word");
        rd_chk(12'h1C8, 32'hFE24_0000, "R2 io base");
        rd_chk(12'h1C4, 32'h0, "R2 mem base");
        rd_chk(12'h1C0, 32'h0, "R2 target");

        // header words R1
        wr(12'h000, 32'h1234_5678, "R10 write ack");
        wr(12'h0FC, 32'hDEAD_BEEF, "R10 write ack");
        wr(12'h040, 32'hA5A5_0F0F, "R10 write ack");
        rd_chk(12'h000, 32'h1234_5678, "R1 word 0");
        rd_chk(12'h0FC, 32'hDEAD_BEEF, "R1 word 63");
        rd_chk(12'h040, 32'hA5A5_0F0F, "R1 word 16");
        wr(12'h004, 32'hFFFF_FFFF, "R10 write ack");
        rd_chk(12'h004, 32'hFFFF_FFFF, "R1 cmd/status rewrite");

        // target R3
        wr(12'h1C0, 32'hFFFF_FFFF, "R10 write ack");
        rd_chk(12'h1C0, 32'hFFFF_FFFF, "R3 all ones");
        wr(12'h1C0, 32'h8000_1235, "R10 write ack");
        rd_chk(12'h1C0, 32'h8000_1235, "R3 pattern");

        // memory base R4
        wr(12'h1C4, 32'hFFFF_FFFF, "R10 write ack");
        rd_chk(12'h1C4, 32'hFF00_0001, "R4 mask all ones");
        wr(12'h1C4, 32'h1234_5678, "R10 write ack");
        rd_chk(12'h1C4, 32'h1200_0000, "R4 mask pattern");

        // I/O base R5
        wr(12'h1C8, 32'h1000_FFFF, "R10 write ack");
        rd_chk(12'h1C8, 32'h1000_0001, "R5 moved and masked");
        wr(12'h1C8, 32'h1000_0000, "R10 write ack");
        rd_chk(12'h1C8, 32'h1000_0001, "R5 same upper bits ignored");
        wr(12'h1C8, 32'h1003_FFFE, "R10 write ack");
        rd_chk(12'h1C8, 32'h1000_0001, "R5 low bits only ignored");
        wr(12'h1C8, 32'h1004_0000, "R10 write ack");
        rd_chk(12'h1C8, 32'h1004_0000, "R5 moved again");
        repeat (8) @(posedge clk);

        // undecoded R8
        wr(12'h100, 32'hFFFF_FFFF, "R10 write ack");
        rd_chk(12'h100, 32'h0, "R8 gap above header");
        rd_chk(12'h000, 32'h1234_5678, "R8 no alias into header");
        rd_chk(12'h1CC, 32'h0, "R8 gap after io base");
        wr(12'h224, 32'hFFFF_FFFF, "R10 write ack");
        rd_chk(12'h224, 32'h0, "R8 past end");
        rd_chk(12'h400, 32'h0, "R8 high offset");
        wr(12'h006, 32'h0BAD_0BAD, "R10 write ack");
        rd_chk(12'h004, 32'hFFFF_FFFF, "R8 misaligned write dropped");
        rd_chk(12'h005, 32'h0, "R8 misaligned read");
        wr(12'h1C2, 32'h0000_0000, "R10 write ack");
        rd_chk(12'h1C0, 32'h8000_1235, "R8 misaligned target write dropped");
        chk(seen_cnt == 0, "R8 no stray config request", seen_cnt, 0);

        // data port R7
        wr(12'h1C0, 32'h8000_0810, "R10 write ack");
        cfg_lat = 3;
        acc(1'b1, 12'h220, 32'hCAFE_F00D, r, w);
        chk(seen_addr == 32'h8000_0810, "R7 write address", seen_addr, 32'h8000_0810);
        chk(seen_we == 1'b1, "R7 write flag", {31'b0, seen_we}, 32'd1);
        chk(seen_wdata == 32'hCAFE_F00D, "R7 write data", seen_wdata, 32'hCAFE_F00D);
        chk(w >= 3, "R7 stalled until ready", w, 3);
        cfg_lat = 0;
        acc(1'b0, 12'h220, '0, r, w);
        chk(r == 32'hCAFE_F00D, "R7 read back", r, 32'hCAFE_F00D);
        chk(seen_we == 1'b0, "R7 read flag", {31'b0, seen_we}, 32'd0);
        chk(w >= 1, "R7 read stalls", w, 1);
        wr(12'h1C0, 32'h8000_1000, "R10 write ack");
        cfg_lat = 5;
        acc(1'b0, 12'h220, '0, r, w);
        chk(r == (32'h8000_1000 ^ 32'h5A5A_5A5A), "R7 read follows target", r, 32'h8000_1000 ^ 32'h5A5A_5A5A);
        chk(seen_addr == 32'h8000_1000, "R7 read address", seen_addr, 32'h8000_1000);
        chk(seen_cnt == 3, "R7 one request per access", seen_cnt, 3);

        // interrupts R9
        irq_send(8'h08, 1'b1);
        irq_send(8'h1F, 1'b1);
        irq_send(8'h20, 1'b1);
        irq_send(8'hFF, 1'b1);
        irq_send(8'h03, 1'b1);
        irq_send(8'h0D, 1'b0);
        irq_send(8'h10, 1'b1);
        @(negedge clk); #1;
        chk(irq_out == 4'b1101, "R9 final lines", {28'b0, irq_out}, 32'hD);

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule